// File: doc/BRIEF.md
# Paged Data Flash Command Controller

This block fronts a small non-volatile data array of byte cells grouped into four-byte pages. A host reaches it through a narrow register port: four data holding registers, a low and a high address byte, and a command register. Writing a code into the command register starts an operation. The operation can be a page read, a page program, a page compare, a page erase, an erase of the whole array, a single-byte read or a single-byte program. The array is held as internal storage. The cells keep the one behaviour of real flash that software depends on: erased cells read as all ones, and programming can only clear bits.

Each accepted command holds the block busy for a fixed number of cycles and executes in the last of them. While busy, every host write is dropped. Reading the command register returns a status code. It is zero after a successful command or a matching compare, and nonzero after a failed compare, an unknown code or an address outside the array. Page commands treat the sixteen address bits as a page number. Byte commands treat them as a byte address, and the low two bits of that address pick the byte within the page.

Top module: `dflash_ctrl`

## Requirements
- R1: After reset, busy is low, every readable register (select 0 to 7) reads 00h, and every byte of the array reads FFh.
- R2: Command 01h with a page number below PAGES copies page bytes 0..3 into data registers 0..3 (register select 0 receives the byte at offset 0).
- R3: Command 02h with a valid page number programs all four bytes of the page, each stored byte becoming the old byte AND the data register of the same offset.
- R4: Command 04h with a valid page number leaves the array and the data registers untouched and sets the status readback to 00h when all four data registers equal the page bytes, or to 01h otherwise.
- R5: Command 05h with a valid page number returns that page's four bytes to FFh and leaves all other pages unchanged.
- R6: Command 06h returns every byte of the array to FFh, whatever the address registers hold.
- R7: Command 81h with a byte address below 4*PAGES copies that byte into data register 0 and leaves data registers 1..3 unchanged.
- R8: Command 82h with a valid byte address stores the old byte AND data register 0 at that address and leaves the other three bytes of the page unchanged.
- R9: Any command code other than 01h, 02h, 04h, 05h, 06h, 81h and 82h (the reserved 03h included) changes neither the array nor the data registers and sets the status readback to 02h.
- R10: A page command whose address is PAGES or more, or a byte command whose address is 4*PAGES or more, changes neither the array nor the data registers and sets the status readback to 03h.
- R11: A command write raises busy from the next cycle for exactly BUSY_CYCLES cycles. The status readback changes only when the command completes, and it reads 00h after any successful command other than a failed compare.
- R12: Host writes to any register while busy is high are ignored, and a command written while busy is never executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Host write strobe for one cycle |
| bus_sel | input | 3 | Register select: 0..3 data, 4 address low, 5 address high, 6 command/status, 7 unused (reads 00h) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data of the register picked by bus_sel, combinational |
| busy | output | 1 | High while a command is in progress |

## Verification
The bench builds the controller with PAGES set to 64 and BUSY_CYCLES set to 3. The array is then small enough that random page and byte addresses often land on the last page and just past its end. An erase of the whole array, and a sweep that reads back every page against the bench's model, each take only a few hundred cycles. The short busy window lets a handful of host writes be injected while a command is still in progress.

// File: rtl/dflash_pkg.sv
// Shared codes and types for the paged data flash controller.
// Assumes an 8-bit host register port and four-byte pages.
package dflash_pkg;

    // Command codes written to the command register.
    localparam logic [7:0] CMD_PG_RD     = 8'h01;
    localparam logic [7:0] CMD_PG_WR     = 8'h02;
    localparam logic [7:0] CMD_VERIFY    = 8'h04;
    localparam logic [7:0] CMD_PG_ERASE  = 8'h05;
    localparam logic [7:0] CMD_ALL_ERASE = 8'h06;
    localparam logic [7:0] CMD_BYTE_RD   = 8'h81;
    localparam logic [7:0] CMD_BYTE_WR   = 8'h82;

    // Status codes returned by reading the command register.
    localparam logic [7:0] STAT_OK       = 8'h00;
    localparam logic [7:0] STAT_MISMATCH = 8'h01;
    localparam logic [7:0] STAT_BADCMD   = 8'h02;
    localparam logic [7:0] STAT_RANGE    = 8'h03;

    // Host register selects.
    localparam logic [2:0] SEL_ADDR_LO = 3'd4;
    localparam logic [2:0] SEL_ADDR_HI = 3'd5;
    localparam logic [2:0] SEL_CMD     = 3'd6;

    localparam int PAGE_BYTES = 4;

    // One array operation, issued in the completion cycle of a command.
    typedef struct packed {
        logic                  wr;
        logic [PAGE_BYTES-1:0] mask;
        logic                  erase_pg;
        logic                  erase_all;
    } arr_op_t;

endpackage

// File: rtl/dflash_array.sv
// Storage of PAGES four-byte pages with flash-like semantics.
// A per-page programmed flag stands in for the erased state, so a page
// erase or a full erase is a flag update, not a sweep of the storage.
// Assumes at most one operation per cycle; read is combinational.
module dflash_array
    import dflash_pkg::*;
#(
    parameter int PAGES = 1024,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int WORD_W = PAGE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] pg,
    input  arr_op_t           op,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [PAGES];
    logic [PAGES-1:0]  prog_q;
    logic [WORD_W-1:0] merged;

    // Present the page as all ones until it has been programmed.
    always_comb rdata = prog_q[pg] ? mem[pg] : '1;

    // Per byte, programming clears bits only in the selected lanes.
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
        always_comb begin
            merged[b*8 +: 8] = op.mask[b] ? (rdata[b*8 +: 8] & wdata[b*8 +: 8])
                                          : rdata[b*8 +: 8];
        end
    end

    // Store the merged page word on a program operation.
    always_ff @(posedge clk) begin
        if (op.wr) mem[pg] <= merged;
    end

    // Track which pages hold programmed content.
    always_ff @(posedge clk) begin
        if (!rst_n)           prog_q     <= '0;
        else if (op.erase_all) prog_q    <= '0;
        else if (op.erase_pg) prog_q[pg] <= 1'b0;
        else if (op.wr)       prog_q[pg] <= 1'b1;
    end

endmodule

// File: rtl/dflash_regs.sv
// Host-visible register file: four data bytes, a 16-bit address and the
// readback multiplexer. Host writes arrive already gated by busy.
// Array loads take priority over host writes in the same cycle.
module dflash_regs
    import dflash_pkg::*;
#(
    localparam int WORD_W = PAGE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        sel,
    input  logic [7:0]        wdata,
    input  logic              ld_page,
    input  logic [WORD_W-1:0] page_data,
    input  logic              ld_byte,
    input  logic [7:0]        byte_data,
    input  logic [7:0]        status,
    output logic [WORD_W-1:0] data_q,
    output logic [15:0]       addr_q,
    output logic [7:0]        rdata
);

    // One holding register per page offset; offset 0 also takes byte reads.
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_data
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[b*8 +: 8] <= '0;
            else if (ld_page)
                data_q[b*8 +: 8] <= page_data[b*8 +: 8];
            else if ((b == 0) && ld_byte)
                data_q[b*8 +: 8] <= byte_data;
            else if (host_we && (sel == 3'(b)))
                data_q[b*8 +: 8] <= wdata;
        end
    end

    // Address bytes written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (host_we) begin
            if (sel == SEL_ADDR_LO) addr_q[7:0]  <= wdata;
            if (sel == SEL_ADDR_HI) addr_q[15:8] <= wdata;
        end
    end

    // Readback multiplexer for the selected register.
    always_comb begin
        case (sel)
            3'd0:        rdata = data_q[7:0];
            3'd1:        rdata = data_q[15:8];
            3'd2:        rdata = data_q[23:16];
            3'd3:        rdata = data_q[31:24];
            SEL_ADDR_LO: rdata = addr_q[7:0];
            SEL_ADDR_HI: rdata = addr_q[15:8];
            SEL_CMD:     rdata = status;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/dflash_seq.sv
// Command sequencer: latches a command, holds busy for BUSY_CYCLES cycles,
// and in the last busy cycle decodes the command into array operations,
// register loads and a status code. Assumes cmd_we is only raised when idle
// and that the address and data registers do not move while busy.
module dflash_seq
    import dflash_pkg::*;
#(
    parameter int PAGES       = 1024,
    parameter int BUSY_CYCLES = 4,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1),
    localparam int WORD_W = PAGE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_wdata,
    input  logic [15:0]       addr_q,
    input  logic [WORD_W-1:0] data_q,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic              busy,
    output logic [7:0]        status,
    output logic [PAGE_W-1:0] pg,
    output arr_op_t           arr_op,
    output logic [WORD_W-1:0] arr_wdata,
    output logic              ld_page,
    output logic              ld_byte,
    output logic [7:0]        byte_data
);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       cmd_q;
    logic [7:0]       status_q;
    logic [7:0]       st_next;
    logic             exec;
    logic             page_ok;
    logic             byte_ok;
    logic [1:0]       off;

    assign exec   = busy_q && (cnt_q == '0);
    assign busy   = busy_q;
    assign status = status_q;
    assign off    = addr_q[1:0];

    // Busy window timer and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cmd_q  <= '0;
        end else if (cmd_we) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
            cmd_q  <= cmd_wdata;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Address range checks for page and byte interpretation.
    always_comb begin
        page_ok = {16'b0, addr_q} < 32'(PAGES);
        byte_ok = {16'b0, addr_q} < 32'(PAGES * PAGE_BYTES);
    end

    // Page index: byte commands drop the two offset bits.
    always_comb pg = cmd_q[7] ? addr_q[PAGE_W+1:2] : addr_q[PAGE_W-1:0];

    // Byte lane picked out of the addressed page.
    always_comb byte_data = arr_rdata[{off, 3'b000} +: 8];

    // Command decode into strobes and the completion status.
    always_comb begin
        arr_op    = '0;
        arr_wdata = data_q;
        ld_page   = 1'b0;
        ld_byte   = 1'b0;
        st_next   = STAT_OK;
        case (cmd_q)
            CMD_PG_RD: begin
                if (page_ok) ld_page = exec;
                else         st_next = STAT_RANGE;
            end
            CMD_PG_WR: begin
                if (page_ok) begin
                    arr_op.wr   = exec;
                    arr_op.mask = '1;
                end else begin
                    st_next = STAT_RANGE;
                end
            end
            CMD_VERIFY: begin
                if (page_ok) st_next = (arr_rdata == data_q) ? STAT_OK : STAT_MISMATCH;
                else         st_next = STAT_RANGE;
            end
            CMD_PG_ERASE: begin
                if (page_ok) arr_op.erase_pg = exec;
                else         st_next = STAT_RANGE;
            end
            CMD_ALL_ERASE: arr_op.erase_all = exec;
            CMD_BYTE_RD: begin
                if (byte_ok) ld_byte = exec;
                else         st_next = STAT_RANGE;
            end
            CMD_BYTE_WR: begin
                arr_wdata = {PAGE_BYTES{data_q[7:0]}};
                if (byte_ok) begin
                    arr_op.wr   = exec;
                    arr_op.mask = PAGE_BYTES'(1) << off;
                end else begin
                    st_next = STAT_RANGE;
                end
            end
            default: st_next = STAT_BADCMD;
        endcase
    end

    // Status register, updated only when a command completes.
    always_ff @(posedge clk) begin
        if (!rst_n)    status_q <= STAT_OK;
        else if (exec) status_q <= st_next;
    end

endmodule

// File: rtl/dflash_ctrl.sv
// Top of the paged data flash controller. Gates host writes with busy and
// wires the register file, the command sequencer and the storage array.
// Assumes a single host, one register access per cycle.
module dflash_ctrl
    import dflash_pkg::*;
#(
    parameter int PAGES       = 1024,
    parameter int BUSY_CYCLES = 4,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int WORD_W = PAGE_BYTES * 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [2:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       busy
);

    logic              host_we;
    logic              cmd_we;
    logic [WORD_W-1:0] data_q;
    logic [15:0]       addr_q;
    logic [7:0]        status;
    logic [PAGE_W-1:0] pg;
    arr_op_t           arr_op;
    logic [WORD_W-1:0] arr_wdata;
    logic [WORD_W-1:0] arr_rdata;
    logic              ld_page;
    logic              ld_byte;
    logic [7:0]        byte_data;

    // Drop every host write while a command is in progress.
    always_comb begin
        host_we = bus_wr && !busy;
        cmd_we  = host_we && (bus_sel == SEL_CMD);
    end

    dflash_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .sel       (bus_sel),
        .wdata     (bus_wdata),
        .ld_page   (ld_page),
        .page_data (arr_rdata),
        .ld_byte   (ld_byte),
        .byte_data (byte_data),
        .status    (status),
        .data_q    (data_q),
        .addr_q    (addr_q),
        .rdata     (bus_rdata)
    );

    dflash_seq #(
        .PAGES       (PAGES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (bus_wdata),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .arr_rdata (arr_rdata),
        .busy      (busy),
        .status    (status),
        .pg        (pg),
        .arr_op    (arr_op),
        .arr_wdata (arr_wdata),
        .ld_page   (ld_page),
        .ld_byte   (ld_byte),
        .byte_data (byte_data)
    );

    dflash_array #(
        .PAGES (PAGES)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .pg    (pg),
        .op    (arr_op),
        .wdata (arr_wdata),
        .rdata (arr_rdata)
    );

endmodule

// File: rtl/dflash_ctrl_chk.sv
// Protocol checker for dflash_ctrl, attached by bind. Observes busy timing,
// register stability during commands and the range of status codes.
module dflash_ctrl_chk
    import dflash_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [2:0]  bus_sel,
    input logic        busy,
    input logic [31:0] data_q,
    input logic [15:0] addr_q,
    input logic [7:0]  status,
    input logic        ld_page,
    input logic        ld_byte
);

    logic [15:0] run_q;

    // Length of the current busy run, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    assert_busy_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 16'(BUSY_CYCLES)));

    assert_cmd_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && (bus_sel == SEL_CMD)) |=> busy);

    assert_status_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(status));

    assert_data_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ld_page && !ld_byte) |=> $stable(data_q));

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q));

    assert_status_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status <= STAT_RANGE);

    assert_one_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_page, ld_byte}));

endmodule

bind dflash_ctrl dflash_ctrl_chk #(
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_sel (bus_sel),
    .busy    (busy),
    .data_q  (data_q),
    .addr_q  (addr_q),
    .status  (status),
    .ld_page (ld_page),
    .ld_byte (ld_byte)
);

// File: tb/dflash_ctrl_tb.sv
`timescale 1ns/1ps
module dflash_ctrl_tb;

    localparam int PAGES = 64;
    localparam int BUSY  = 3;
    localparam int NB    = PAGES * 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_sel = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       busy;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] mem_m [NB];
    logic [7:0] exp_d [4];
    logic [15:0] exp_a = '0;

    dflash_ctrl #(.PAGES(PAGES), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
        bus_sel = sel; bus_wdata = val; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [7:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
        @(negedge clk);
    endtask

    task automatic set_addr(input logic [15:0] a);
        wr_reg(3'd4, a[7:0]);
        wr_reg(3'd5, a[15:8]);
        exp_a = a;
    endtask

    task automatic set_data(input int i, input logic [7:0] v);
        wr_reg(3'(i), v);
        exp_d[i] = v;
    endtask

    // Reference model of one command, from the requirements.
    task automatic model(input logic [7:0] code, output logic [7:0] st);
        int a = int'(exp_a);
        bit eq = 1'b1;
        st = 8'h00;
        case (code)
            8'h01: if (a < PAGES) for (int i = 0; i < 4; i++) exp_d[i] = mem_m[a*4+i]; else st = 8'h03;
            8'h02: if (a < PAGES) for (int i = 0; i < 4; i++) mem_m[a*4+i] &= exp_d[i]; else st = 8'h03;
            8'h04: if (a < PAGES) begin
                       for (int i = 0; i < 4; i++) if (mem_m[a*4+i] != exp_d[i]) eq = 1'b0;
                       st = eq ? 8'h00 : 8'h01;
                   end else st = 8'h03;
            8'h05: if (a < PAGES) for (int i = 0; i < 4; i++) mem_m[a*4+i] = 8'hFF; else st = 8'h03;
            8'h06: for (int i = 0; i < NB; i++) mem_m[i] = 8'hFF;
            8'h81: if (a < NB) exp_d[0] = mem_m[a]; else st = 8'h03;
            8'h82: if (a < NB) mem_m[a] &= exp_d[0]; else st = 8'h03;
            default: st = 8'h02;
        endcase
    endtask

    function automatic string req_of(input logic [7:0] code, input logic [7:0] st);
        if (st == 8'h03) return "R10";
        case (code)
            8'h01: return "R2";
            8'h02: return "R3";
            8'h04: return "R4";
            8'h05: return "R5";
            8'h06: return "R6";
            8'h81: return "R7";
            8'h82: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_regs(input string req);
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            rd_reg(3'(i), v);
            check(v == exp_d[i], req, v, exp_d[i]);
        end
    endtask

    // Issue a command, check busy length, status and data registers.
    task automatic do_cmd(input logic [7:0] code, input string force_req);
        int n = 0;
        logic [7:0] st, v;
        string req;
        wr_reg(3'd6, code);
        while (busy && n < 100) begin n++; @(negedge clk); end
        check(n == BUSY, "R11", n, BUSY);
        model(code, st);
        req = (force_req != "") ? force_req : req_of(code, st);
        rd_reg(3'd6, v);
        check(v == st, req, v, st);
        check_regs(req);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++; total++;
            $display("FAIL R11 watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) mem_m[i] = 8'hFF;
        for (int i = 0; i < 4; i++) exp_d[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every register and busy.
        check(busy == 1'b0, "R1", busy, 0);
        for (int s = 0; s < 8; s++) begin
            rd_reg(3'(s), v);
            check(v == 8'h00, "R1", v, 0);
        end
        // R1: whole array erased after reset.
        for (int p = 0; p < PAGES; p++) begin
            set_addr(16'(p));
            do_cmd(8'h01, "R1");
        end

        // R3: programming only clears bits.
        set_addr(16'd0);
        set_data(0, 8'hA5); set_data(1, 8'h3C); set_data(2, 8'hFF); set_data(3, 8'h81);
        do_cmd(8'h02, "R3");
        set_data(0, 8'h0F); set_data(1, 8'hF0); set_data(2, 8'h55); set_data(3, 8'hFF);
        do_cmd(8'h02, "R3");
        do_cmd(8'h01, "R3");

        // R4: compare match, then mismatch.
        do_cmd(8'h04, "R4");
        set_data(2, 8'h54);
        do_cmd(8'h04, "R4");
        do_cmd(8'h01, "R4");

        // R8: byte program on an erased page keeps other bytes erased.
        set_addr(16'(NB - 1));
        set_data(0, 8'h12);
        do_cmd(8'h82, "R8");
        set_addr(16'(PAGES - 1));
        do_cmd(8'h01, "R8");
        // R7: byte read touches register 0 only.
        set_data(1, 8'h77); set_data(2, 8'h66); set_data(3, 8'h55);
        set_addr(16'(NB - 1));
        do_cmd(8'h81, "R7");

        // R9: reserved and unknown codes.
        do_cmd(8'h03, "R9");
        do_cmd(8'hF0, "R9");
        // R10: just past the end, for page and byte commands.
        set_addr(16'(PAGES));
        do_cmd(8'h05, "R10");
        set_addr(16'(NB));
        do_cmd(8'h82, "R10");
        set_addr(16'(PAGES - 1));
        do_cmd(8'h01, "R10");

        // R12: writes during busy are dropped, a command among them too.
        set_addr(16'd5);
        set_data(0, 8'hC3);
        wr_reg(3'd6, 8'h02);
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd6, 8'h06);
        while (busy) @(negedge clk);
        model(8'h02, v);
        @(negedge clk);
        check(busy == 1'b0, "R12", busy, 0);
        rd_reg(3'd6, v);
        check(v == 8'h00, "R12", v, 0);
        do_cmd(8'h01, "R12");
        set_addr(16'd0);
        do_cmd(8'h01, "R12");

        // R5 and R6: erase one page, then the whole array.
        do_cmd(8'h05, "R5");
        set_addr(16'd5);
        do_cmd(8'h01, "R5");
        do_cmd(8'h06, "R6");
        do_cmd(8'h01, "R6");

        // Random mix against the model.
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom % 16);
            logic [7:0] code;
            logic [15:0] a;
            case (r)
                0, 1, 2:  code = 8'h01;
                3, 4, 5:  code = 8'h02;
                6, 7:     code = 8'h04;
                8, 9:     code = 8'h05;
                10:       code = 8'h06;
                11, 12:   code = 8'h81;
                13, 14:   code = 8'h82;
                default:  code = 8'($urandom);
            endcase
            for (int i = 0; i < 4; i++)
                if ($urandom % 2 == 0) set_data(i, 8'($urandom));
            if ($urandom % 8 == 0)   a = 16'($urandom);
            else if (code[7])        a = 16'($urandom % (NB + 2));
            else                     a = 16'($urandom % (PAGES + 1));
            set_addr(a);
            do_cmd(code, "");
        end

        // Final sweep of the array against the model.
        for (int p = 0; p < PAGES; p++) begin
            set_addr(16'(p));
            do_cmd(8'h01, "R2");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule